// File: doc/BRIEF.md
# Key-Protected Voltage Configuration Register File

This block is the byte-wide register bank that sits behind a two-wire serial slave in a voltage-regulator translator. An external byte engine decodes the serial bus and presents an index, a write-data byte and single-cycle write and read strobes. The bank holds per-rail base voltage codes and signed offsets, a step-time code, two over-voltage multiplier selects, a manual-mode control with two mirror bits, an enable for clearing by an external pin, a countdown watchdog and two fixed identification bytes. Every field is driven as a registered output to the neighbouring blocks.

The voltage-affecting registers are protected. They accept writes only after a four-byte unlock key has been written to the key index, and a single relock byte closes them again. Two events wipe the protected state and the key. The first is the watchdog reaching zero on a prescaler tick. The second, when enabled, is a low level on the clear pin, seen after a synchroniser. After a wipe, software must unlock again before it can retune anything.

Top module: `vreg_cfg_bank`

## Requirements
- R1: Writing 0x32, 0x5D, 0x42 and 0xAC in that order to index 0x03 unlocks the bank. A read of index 0x03 returns 0xFF while unlocked and 0x00 while locked.
- R2: While unlocked, writing 0x35 to index 0x03 relocks the bank. Any other byte written to index 0x03 while unlocked leaves it unlocked.
- R3: Indexes 0x00 to 0x02 (base codes) and 0x04 to 0x0A accept writes only while unlocked. A write while locked leaves them unchanged.
- R4: While locked, a key byte that does not match the next expected byte restarts matching. If that byte is 0x32, it counts as the first key byte.
- R5: Index 0x13 holds the watchdog. Bit 7 is the enable and bits 6:0 are the count, and a write to it is always accepted. On each tick while enabled, the count decrements. On a tick with the count at zero, the block fires once: it clears the protected registers and the key, clears the enable, and raises wipe_pulse for exactly one cycle. Loading count 0 with the enable set fires on the next tick.
- R6: Index 0x0F bit 0 (reset 0) enables pin clearing. While it is 1, a low level on clr_pin_n, after a two-flop synchroniser, wipes the protected registers and the key. While it is 0, the pin has no effect.
- R7: Reset and wipe values: index 0x07 bits 3:0 are 2, and all other protected fields are 0. Only certain bits are stored, and the unstored bits read 0. Index 0x07 stores bits 3:0. Indexes 0x08 and 0x09 store bits 4:0. Index 0x0A stores bit 0 (manual enable), bit 4 (mirror of the north-bridge rail) and bit 5 (mirror of core rail 0).
- R8: Index 0x5D reads 0x19 and index 0x5E reads 0x34. The addr_byte output is 0x5C.
- R9: Reads of indexes that are not implemented return 0x00. Writes to them change nothing.
- R10: rdata updates on the clock edge that samples rd_stb, and it holds its value when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| idx | input | 8 | Register index |
| wdata | input | 8 | Write data |
| tick | input | 1 | Watchdog prescaler pulse |
| clr_pin_n | input | 1 | Asynchronous active-low clear pin |
| rdata | output | 8 | Registered read data |
| unlocked | output | 1 | Key accepted |
| wipe_pulse | output | 1 | One-cycle flag that a wipe occurred |
| addr_byte | output | 8 | Slave address byte for the bus engine |
| base_nb | output | 8 | North-bridge rail base code |
| base_c0 | output | 8 | Core rail 0 base code |
| base_c1 | output | 8 | Core rail 1 base code |
| ofs_nb | output | 8 | North-bridge offset, two's complement |
| ofs_c0 | output | 8 | Core rail 0 offset, two's complement |
| ofs_c1 | output | 8 | Core rail 1 offset, two's complement |
| step_sel | output | 4 | North-bridge step time code |
| ovs_a | output | 5 | Over-voltage select, channel A |
| ovs_b | output | 5 | Over-voltage select, channel B |
| man_en | output | 1 | Manual mode enable |
| mir_nb | output | 1 | North-bridge mirror |
| mir_c0 | output | 1 | Core rail 0 mirror |

## Verification
The hardest cases to reach are the ones where the key state interacts with a wipe. One is a watchdog firing while the bank is unlocked and holds non-reset values. Another is an interrupted key sequence whose breaking byte is itself the first key byte. The stimulus unlocks the bank, dirties the protected registers, and then loads the watchdog with a small count. It then issues a counted number of ticks, including a zero-count load that must fire on the very next tick. Separately, it feeds key streams that break at different positions. A behavioural model runs alongside and is compared with every output on every clock.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int NPROT = 10;
  localparam int NKEY  = 4;

  localparam logic [7:0] IX_KEY    = 8'h03;
  localparam logic [7:0] IX_PINEN  = 8'h0F;
  localparam logic [7:0] IX_WDOG   = 8'h13;
  localparam logic [7:0] IX_ID_A   = 8'h5D;
  localparam logic [7:0] IX_ID_B   = 8'h5E;

  localparam logic [7:0] RELOCK    = 8'h35;
  localparam logic [7:0] ID_A      = 8'h19;
  localparam logic [7:0] ID_B      = 8'h34;
  localparam logic [7:0] ADDR_BYTE = 8'h5C;

  function automatic logic [7:0] key_byte(input int i);
    case (i)
      0: return 8'h32;
      1: return 8'h5D;
      2: return 8'h42;
      default: return 8'hAC;
    endcase
  endfunction

  // protected slot s lives at index s for s<3, else s+1 (0x03 is the key)
  function automatic logic [7:0] slot_index(input int s);
    return (s < 3) ? 8'(s) : 8'(s + 1);
  endfunction

  function automatic logic [7:0] slot_mask(input int s);
    case (s)
      6:       return 8'h0F;
      7, 8:    return 8'h1F;
      9:       return 8'h31;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slot_rst(input int s);
    return (s == 6) ? 8'h02 : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
  import cfgbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       wipe,
  output logic       unlocked
);
  localparam int SW = $clog2(NKEY + 1);

  logic [SW-1:0] stage_q;

  always_comb unlocked = (stage_q == SW'(NKEY));

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      stage_q <= '0;
    end else if (key_wr) begin
      if (unlocked) begin
        if (key_data == RELOCK) stage_q <= '0;
      end else if (key_data == key_byte(int'(stage_q))) begin
        stage_q <= stage_q + 1'b1;
      end else begin
        stage_q <= (key_data == key_byte(0)) ? SW'(1) : '0;
      end
    end
  end

  p_unlock_last_byte_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && key_data == key_byte(NKEY - 1)));

  p_relock_r2: assert property (@(posedge clk) disable iff (rst)
    (unlocked && key_wr && key_data == RELOCK) |=> !unlocked);

  p_stay_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !wipe && !(key_wr && key_data == RELOCK)) |=> unlocked);

  p_wipe_clears_key_r5: assert property (@(posedge clk) disable iff (rst)
    wipe |=> !unlocked);
endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_en,
  input  logic [CW-1:0] load_cnt,
  input  logic          tick,
  output logic          en_q,
  output logic [CW-1:0] cnt_q,
  output logic          fire
);
  always_comb fire = tick && en_q && (cnt_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      en_q  <= load_en;
      cnt_q <= load_cnt;
    end else if (tick && en_q) begin
      if (cnt_q == '0) en_q  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  p_wd_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
    fire |=> !en_q);

  p_wd_step_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && en_q && cnt_q != '0 && !load) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_low
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_comb pin_low = ~sr_q[STAGES-1];
endmodule

// File: rtl/cfg_prot_bank.sv
module cfg_prot_bank
  import cfgbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic [7:0]            idx,
  input  logic [7:0]            wdata,
  input  logic                  unlocked,
  input  logic                  wipe,
  output logic [NPROT-1:0][7:0] q
);
  generate
    for (genvar s = 0; s < NPROT; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst || wipe) begin
          q[s] <= slot_rst(s);
        end else if (wr_stb && unlocked && idx == slot_index(s)) begin
          q[s] <= wdata & slot_mask(s);
        end
      end
    end
  endgenerate

  p_locked_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !wipe) |=> $stable(q));
endmodule

// File: rtl/vreg_cfg_bank.sv
module vreg_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WD_W        = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  logic       clr_pin_n,
  output logic [7:0] rdata,
  output logic       unlocked,
  output logic       wipe_pulse,
  output logic [7:0] addr_byte,
  output logic [7:0] base_nb,
  output logic [7:0] base_c0,
  output logic [7:0] base_c1,
  output logic [7:0] ofs_nb,
  output logic [7:0] ofs_c0,
  output logic [7:0] ofs_c1,
  output logic [3:0] step_sel,
  output logic [4:0] ovs_a,
  output logic [4:0] ovs_b,
  output logic       man_en,
  output logic       mir_nb,
  output logic       mir_c0
);
  localparam int PAD = 7 - WD_W;

  logic [NPROT-1:0][7:0] prot_q;
  logic                  pin_low;
  logic                  pinen_q;
  logic                  wd_en;
  logic [WD_W-1:0]       wd_cnt;
  logic                  wd_fire;
  logic                  wipe_req;
  logic                  wd_load;
  logic [7:0]            rd_mux;

  always_comb wipe_req = wd_fire || (pinen_q && pin_low);
  always_comb wd_load  = wr_stb && (idx == IX_WDOG);

  cfg_key_lock i_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_stb && idx == IX_KEY),
    .key_data (wdata),
    .wipe     (wipe_req),
    .unlocked (unlocked)
  );

  cfg_watchdog #(.CW(WD_W)) i_wd (
    .clk      (clk),
    .rst      (rst),
    .load     (wd_load),
    .load_en  (wdata[7]),
    .load_cnt (wdata[WD_W-1:0]),
    .tick     (tick),
    .en_q     (wd_en),
    .cnt_q    (wd_cnt),
    .fire     (wd_fire)
  );

  cfg_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n   (clr_pin_n),
    .pin_low (pin_low)
  );

  cfg_prot_bank i_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .idx      (idx),
    .wdata    (wdata),
    .unlocked (unlocked),
    .wipe     (wipe_req),
    .q        (prot_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pinen_q <= 1'b0;
    else if (wr_stb && idx == IX_PINEN) pinen_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) wipe_pulse <= 1'b0;
    else     wipe_pulse <= wipe_req;
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int s = 0; s < NPROT; s++) begin
      if (idx == slot_index(s)) rd_mux = prot_q[s];
    end
    case (idx)
      IX_KEY:   rd_mux = unlocked ? 8'hFF : 8'h00;
      IX_PINEN: rd_mux = {7'd0, pinen_q};
      IX_WDOG:  rd_mux = {wd_en, {PAD{1'b0}}, wd_cnt};
      IX_ID_A:  rd_mux = ID_A;
      IX_ID_B:  rd_mux = ID_B;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= 8'h00;
    else if (rd_stb) rdata <= rd_mux;
  end

  always_comb begin
    addr_byte = ADDR_BYTE;
    base_nb   = prot_q[0];
    base_c0   = prot_q[1];
    base_c1   = prot_q[2];
    ofs_nb    = prot_q[3];
    ofs_c0    = prot_q[4];
    ofs_c1    = prot_q[5];
    step_sel  = prot_q[6][3:0];
    ovs_a     = prot_q[7][4:0];
    ovs_b     = prot_q[8][4:0];
    man_en    = prot_q[9][0];
    mir_nb    = prot_q[9][4];
    mir_c0    = prot_q[9][5];
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rdata));

  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx > IX_ID_B) |=> (rdata == 8'h00));

  p_pin_wipe_r6: assert property (@(posedge clk) disable iff (rst)
    (pinen_q && pin_low) |=> (wipe_pulse && !unlocked));
endmodule

// File: tb/test_vreg_cfg_bank.sv
module test_vreg_cfg_bank;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0, tick = 1'b0, clr_pin_n = 1'b1;
  logic [7:0] idx = 8'h00, wdata = 8'h00;
  logic [7:0] rdata, addr_byte, base_nb, base_c0, base_c1, ofs_nb, ofs_c0, ofs_c1;
  logic [3:0] step_sel;
  logic [4:0] ovs_a, ovs_b;
  logic       unlocked, wipe_pulse, man_en, mir_nb, mir_c0;

  vreg_cfg_bank i_vreg_cfg_bank (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  logic [7:0] mp[10];
  int         mst;
  logic       msen, mwen, mwp;
  logic [6:0] mcnt;
  logic [7:0] mrd;
  logic       mq[$];
  logic [7:0] kb[4] = '{8'h32, 8'h5D, 8'h42, 8'hAC};

  function automatic int mslot(input logic [7:0] i);
    case (i)
      8'h00: return 0; 8'h01: return 1; 8'h02: return 2;
      8'h04: return 3; 8'h05: return 4; 8'h06: return 5;
      8'h07: return 6; 8'h08: return 7; 8'h09: return 8;
      8'h0A: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] mmask(input int s);
    if (s == 6) return 8'h0F;
    if (s == 7 || s == 8) return 8'h1F;
    if (s == 9) return 8'h31;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] i);
    int s;
    if (i == 8'h03) return (mst == 4) ? 8'hFF : 8'h00;
    if (i == 8'h0F) return {7'd0, msen};
    if (i == 8'h13) return {mwen, mcnt};
    if (i == 8'h5D) return 8'h19;
    if (i == 8'h5E) return 8'h34;
    s = mslot(i);
    if (s >= 0) return mp[s];
    return 8'h00;
  endfunction

  task automatic mreset_prot();
    for (int s = 0; s < 10; s++) mp[s] = (s == 6) ? 8'h02 : 8'h00;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mreset_prot();
      mst = 0; msen = 0; mwen = 0; mcnt = 0; mrd = 0; mwp = 0;
      mq = {1'b1, 1'b1};
    end else begin
      bit ld, fire, wipe;
      int s;
      ld   = wr_stb && idx == 8'h13;
      fire = tick && mwen && mcnt == 0 && !ld;
      wipe = fire || (msen && mq[1] == 1'b0);
      if (rd_stb) mrd = mread(idx);
      mwp = wipe;
      s = mslot(idx);
      if (wipe) mreset_prot();
      else if (wr_stb && mst == 4 && s >= 0) mp[s] = wdata & mmask(s);
      if (wipe) mst = 0;
      else if (wr_stb && idx == 8'h03) begin
        if (mst == 4) begin
          if (wdata == 8'h35) mst = 0;
        end else if (wdata == kb[mst]) mst = mst + 1;
        else mst = (wdata == 8'h32) ? 1 : 0;
      end
      if (wr_stb && idx == 8'h0F) msen = wdata[0];
      if (ld) begin
        mwen = wdata[7]; mcnt = wdata[6:0];
      end else if (tick && mwen) begin
        if (mcnt == 0) mwen = 0;
        else mcnt = mcnt - 1'b1;
      end
      mq.push_front(clr_pin_n);
      void'(mq.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 unlocked flag", 128'(unlocked), 128'(mst == 4));
      chk("R5 wipe pulse", 128'(wipe_pulse), 128'(mwp));
      chk("R10 rdata", 128'(rdata), 128'(mrd));
      chk("R3 fields",
          128'({base_nb, base_c0, base_c1, ofs_nb, ofs_c0, ofs_c1, step_sel, ovs_a, ovs_b, man_en, mir_nb, mir_c0}),
          128'({mp[0], mp[1], mp[2], mp[3], mp[4], mp[5], mp[6][3:0], mp[7][4:0], mp[8][4:0], mp[9][0], mp[9][4], mp[9][5]}));
    end
  end

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); wr_stb = 1; idx = i; wdata = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_stb = 1; idx = i;
    @(negedge clk); rd_stb = 0;
    chk(tag, 128'(rdata), 128'(exp));
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic unlock();
    wr(8'h03, 8'h32); wr(8'h03, 8'h5D); wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    rd(8'h03, 8'h00, "R1 locked after reset");
    rd(8'h07, 8'h02, "R7 step reset value");
    rd(8'h0A, 8'h00, "R7 manual reset value");
    rd(8'h0F, 8'h00, "R6 pin enable default");
    rd(8'h5D, 8'h19, "R8 id a");
    rd(8'h5E, 8'h34, "R8 id b");
    chk("R8 addr byte", 128'(addr_byte), 128'(8'h5C));
    // locked writes
    wr(8'h04, 8'h55); wr(8'h00, 8'h11);
    rd(8'h04, 8'h00, "R3 locked write ignored");
    rd(8'h00, 8'h00, "R3 locked base ignored");
    // unlock and write
    unlock();
    rd(8'h03, 8'hFF, "R1 unlocked read");
    wr(8'h04, 8'h55); wr(8'h07, 8'hFF); wr(8'h08, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h00, 8'h80);
    rd(8'h04, 8'h55, "R3 unlocked write");
    rd(8'h07, 8'h0F, "R7 step mask");
    rd(8'h08, 8'h1F, "R7 ov mask");
    rd(8'h0A, 8'h31, "R7 ctrl mask");
    chk("R7 ctrl bits", 128'({man_en, mir_nb, mir_c0}), 128'(3'b111));
    rd(8'h00, 8'h80, "R3 base write");
    // relock
    wr(8'h03, 8'h00);
    rd(8'h03, 8'hFF, "R2 other byte keeps unlock");
    wr(8'h03, 8'h35);
    rd(8'h03, 8'h00, "R2 relock");
    wr(8'h05, 8'h01);
    rd(8'h05, 8'h00, "R3 write after relock");
    // broken sequences
    wr(8'h03, 8'h32); wr(8'h03, 8'h5D); wr(8'h03, 8'h42); wr(8'h03, 8'h00);
    wr(8'h03, 8'h5D); wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
    rd(8'h03, 8'h00, "R4 wrong byte restarts");
    wr(8'h03, 8'h32); wr(8'h03, 8'h5D); wr(8'h03, 8'h32);
    wr(8'h03, 8'h5D); wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
    rd(8'h03, 8'hFF, "R4 breaking 0x32 counts");
    // unimplemented
    wr(8'h20, 8'h77);
    rd(8'h20, 8'h00, "R9 unimplemented read");
    rd(8'h0B, 8'h00, "R9 gap index read");
    // watchdog
    wr(8'h04, 8'h33);
    wr(8'h13, 8'h83);
    rd(8'h13, 8'h83, "R5 watchdog readback");
    tk(); tk(); tk();
    rd(8'h13, 8'h80, "R5 count at zero");
    rd(8'h04, 8'h33, "R5 no wipe before zero tick");
    tk();
    chk("R5 fire pulse", 128'(wipe_pulse), 128'(1));
    @(negedge clk);
    chk("R5 pulse one cycle", 128'(wipe_pulse), 128'(0));
    rd(8'h04, 8'h00, "R5 protected wiped");
    rd(8'h07, 8'h02, "R7 step after wipe");
    rd(8'h03, 8'h00, "R5 key wiped");
    rd(8'h13, 8'h00, "R5 enable self cleared");
    wr(8'h13, 8'h80);
    tk();
    chk("R5 zero load fires", 128'(wipe_pulse), 128'(1));
    // pin clearing
    unlock();
    wr(8'h06, 8'hA5);
    @(negedge clk); clr_pin_n = 0;
    repeat (5) @(negedge clk);
    clr_pin_n = 1;
    repeat (3) @(negedge clk);
    rd(8'h06, 8'hA5, "R6 pin ignored when disabled");
    rd(8'h03, 8'hFF, "R6 key kept when disabled");
    wr(8'h0F, 8'h01);
    rd(8'h0F, 8'h01, "R6 enable readback");
    @(negedge clk); clr_pin_n = 0;
    repeat (5) @(negedge clk);
    clr_pin_n = 1;
    repeat (3) @(negedge clk);
    rd(8'h06, 8'h00, "R6 pin wipes");
    rd(8'h03, 8'h00, "R6 pin clears key");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule